// File: doc/BRIEF.md
# Ramp-Time Timeout Sampler

This block measures how long an external timing ramp takes to charge and turns that time into a watchdog timeout code. The ramp itself and the comparator that watches it sit outside. The block discharges the ramp and then releases it. It counts base-clock ticks until the comparator reports a crossing, and stores the floored tick count as the code. The watchdog that follows uses this code.

Sampling waits until the system reset has been released. If the system reset comes back while a measurement is still running, that measurement is thrown away, and a fresh one starts on the next release. A ramp that trips almost at once, as a missing or open timing element would, gives the zero-timeout code. A ramp that never trips within the counting range gives the infinite code, which the watchdog reads as "disabled". Once a result is stored, it stays until the next power-on reset. A done flag tells the watchdog when the code is valid.

Top module: `ramp_timeout_sampler`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `ramp_en_o`=0, `done_o`=0, `code_o`=0 and `kind_o`=2'b00.
- R2: While `sys_rst_i` is high and no result is stored, `ramp_en_o` stays 0 and nothing is counted.
- R3: After `sys_rst_i` falls, `ramp_en_o` stays 0 (discharge) for DISCH_CYC+1 cycles and then goes to 1. It first reads 1 on the (DISCH_CYC+1)-th rising edge after the release.
- R4: During a measurement, each cycle with `tick_i`=1 and `cmp_i`=0 adds one to the count. In the cycle with `cmp_i`=1, a count n with MIN_CNT <= n < MAX_CNT is stored as `code_o`=n and `kind_o`=2'b01 (normal). `done_o` goes to 1 and `ramp_en_o` goes to 0 at that edge.
- R5: A trip with count n < MIN_CNT stores `code_o`=0 and `kind_o`=2'b00 (zero timeout). The boundary n = MIN_CNT is normal.
- R6: If the MAX_CNT-th tick arrives without a trip, the block stores `code_o` as all ones and `kind_o`=2'b10 (infinite), and sets `done_o`. A trip after MAX_CNT-1 ticks is still normal.
- R7: If `sys_rst_i` rises during discharge or measurement, `ramp_en_o` is 0 from the next edge on. The partial count is discarded, and the next release restarts from discharge with a count of zero.
- R8: Once `done_o` is 1, it holds, and `code_o` and `kind_o` do not change for any `sys_rst_i`, `cmp_i` or `tick_i` activity until `rst_ni` goes low.
- R9: When `cmp_i` and `tick_i` are both 1 in the same cycle, the trip wins and that tick is not counted.
- R10: While `done_o` is 0, `code_o` reads 0 and `kind_o` reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_i | input | 1 | System reset output of the supervisor, high while asserted |
| tick_i | input | 1 | One-cycle pulse per base-clock period |
| cmp_i | input | 1 | Comparator: ramp has crossed its threshold |
| ramp_en_o | output | 1 | 1 lets the ramp charge, 0 discharges it |
| done_o | output | 1 | Stored code is valid |
| code_o | output | CNT_W | Stored timeout code |
| kind_o | output | 2 | 00 zero, 01 normal, 10 infinite |

## Verification
The ramp enable first shows 1 on the (DISCH_CYC+1)-th edge after the system reset is released. An abort shows up one edge after `sys_rst_i` rises. The result and `done_o` appear on the same edge that sees the trip or the final tick. The bench drives its inputs on falling edges and compares every output on every falling edge against a behavioural model that steps on rising edges, so each result is checked in the cycle it is due. Directed sequences hold `tick_i` high, count falling edges from the first one that shows the ramp enabled, and place the trip exactly k edges later. This gives exact expected codes at the MIN_CNT and MAX_CNT boundaries.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [1:0] {
    KIND_ZERO = 2'b00,
    KIND_NORM = 2'b01,
    KIND_INF  = 2'b10
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_DISCH = 2'b01,
    S_MEAS  = 2'b10,
    S_DONE  = 2'b11
  } seq_state_e;
endpackage

// File: rtl/rts_seq.sv
module rts_seq
  import rts_pkg::*;
#(
  parameter int DISCH_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic cmp_i,
  input  logic tick_i,
  input  logic full_i,
  output logic meas_o,
  output logic finish_o,
  output logic inf_o
);
  localparam int DW = (DISCH_CYC < 2) ? 1 : $clog2(DISCH_CYC);
  localparam logic [DW-1:0] DLAST = DW'(DISCH_CYC - 1);

  seq_state_e state_q, state_d;
  logic [DW-1:0] dcnt_q, dcnt_d;

  always_comb begin
    state_d  = state_q;
    dcnt_d   = dcnt_q;
    finish_o = 1'b0;
    inf_o    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (!sys_rst_i) begin
          state_d = S_DISCH;
          dcnt_d  = '0;
        end
      end
      S_DISCH: begin
        if (sys_rst_i)            state_d = S_IDLE;
        else if (dcnt_q == DLAST) state_d = S_MEAS;
        else                      dcnt_d  = dcnt_q + 1'b1;
      end
      S_MEAS: begin
        if (sys_rst_i) begin
          state_d = S_IDLE;
        end else if (cmp_i) begin
          state_d  = S_DONE;
          finish_o = 1'b1;
        end else if (tick_i && full_i) begin
          state_d  = S_DONE;
          finish_o = 1'b1;
          inf_o    = 1'b1;
        end
      end
      S_DONE: state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
    end
  end

  assign meas_o = (state_q == S_MEAS);
endmodule

// File: rtl/rts_tick_cnt.sv
module rts_tick_cnt #(
  parameter int CNT_W   = 8,
  parameter int MAX_CNT = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(MAX_CNT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == FULL_VAL);
endmodule

// File: rtl/rts_result.sv
module rts_result
  import rts_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MIN_CNT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             finish_i,
  input  logic             inf_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             done_o,
  output logic [CNT_W-1:0] code_o,
  output kind_e            kind_o
);
  logic             short_w;
  logic [CNT_W-1:0] code_d;
  kind_e            kind_d;

  generate
    if (MIN_CNT > 0) begin : g_min
      localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_CNT);
      assign short_w = (cnt_i < MIN_VAL);
    end else begin : g_nomin
      assign short_w = 1'b0;
    end
  endgenerate

  always_comb begin
    if (inf_i) begin
      code_d = '1;
      kind_d = KIND_INF;
    end else if (short_w) begin
      code_d = '0;
      kind_d = KIND_ZERO;
    end else begin
      code_d = cnt_i;
      kind_d = KIND_NORM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      code_o <= '0;
      kind_o <= KIND_ZERO;
    end else if (finish_i) begin
      done_o <= 1'b1;
      code_o <= code_d;
      kind_o <= kind_d;
    end
  end
endmodule

// File: rtl/ramp_timeout_sampler.sv
module ramp_timeout_sampler
  import rts_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MIN_CNT   = 3,
  parameter int MAX_CNT   = 200,
  parameter int DISCH_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             ramp_en_o,
  output logic             done_o,
  output logic [CNT_W-1:0] code_o,
  output logic [1:0]       kind_o
);
  logic             meas, finish, inf, full;
  logic [CNT_W-1:0] cnt;
  kind_e            kind;

  rts_seq #(.DISCH_CYC(DISCH_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .cmp_i     (cmp_i),
    .tick_i    (tick_i),
    .full_i    (full),
    .meas_o    (meas),
    .finish_o  (finish),
    .inf_o     (inf)
  );

  rts_tick_cnt #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!meas),
    .inc_i  (meas && tick_i && !cmp_i && !sys_rst_i),
    .cnt_o  (cnt),
    .full_o (full)
  );

  rts_result #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .finish_i (finish),
    .inf_i    (inf),
    .cnt_i    (cnt),
    .done_o   (done_o),
    .code_o   (code_o),
    .kind_o   (kind)
  );

  assign ramp_en_o = meas;
  assign kind_o    = kind;
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
  parameter int CNT_W   = 8,
  parameter int MIN_CNT = 3,
  parameter int MAX_CNT = 200
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_i,
  input logic             ramp_en_o,
  input logic             done_o,
  input logic [CNT_W-1:0] code_o,
  input logic [1:0]       kind_o
);
  AST_RST_STOPS_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && !done_o) |=> !ramp_en_o); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(code_o) && $stable(kind_o))); // R8
  AST_NO_RAMP_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ramp_en_o); // R4
  AST_DONE_AFTER_MEAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(ramp_en_o)); // R4
  AST_NORM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && kind_o == 2'b01) |-> (code_o >= CNT_W'(MIN_CNT) && code_o < CNT_W'(MAX_CNT))); // R4
  AST_ZERO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == 2'b00) |-> (code_o == '0)); // R5
  AST_INF_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == 2'b10) |-> (code_o == '1)); // R6
  AST_IDLE_OUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (code_o == '0 && kind_o == 2'b00)); // R10
endmodule

bind ramp_timeout_sampler rts_checker #(
  .CNT_W(CNT_W), .MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_i (sys_rst_i),
  .ramp_en_o (ramp_en_o),
  .done_o    (done_o),
  .code_o    (code_o),
  .kind_o    (kind_o)
);

// File: tb/ramp_timeout_sampler_test.sv
`timescale 1ns/1ps
module ramp_timeout_sampler_test;
  localparam int CNT_W = 8, MIN_CNT = 3, MAX_CNT = 200, DISCH_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0, sys_rst = 1'b1, tick = 1'b0, cmp = 1'b0;
  logic ramp_en, done;
  logic [CNT_W-1:0] code;
  logic [1:0] kind;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ramp_timeout_sampler #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT),
                         .DISCH_CYC(DISCH_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst), .tick_i(tick), .cmp_i(cmp),
    .ramp_en_o(ramp_en), .done_o(done), .code_o(code), .kind_o(kind));

  // behavioural reference: 0 idle, 1 discharge, 2 measure, 3 stored
  int m_phase, m_dc, m_tc, m_code, m_kind;
  bit m_done;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_dc = 0; m_tc = 0; m_code = 0; m_kind = 0; m_done = 0;
    end else begin
      case (m_phase)
        0: if (!sys_rst) begin m_phase = 1; m_dc = 0; end
        1: if (sys_rst) m_phase = 0;
           else if (m_dc == DISCH_CYC - 1) begin m_phase = 2; m_tc = 0; end
           else m_dc++;
        2: if (sys_rst) m_phase = 0;
           else if (cmp) begin
             m_phase = 3; m_done = 1;
             if (m_tc < MIN_CNT) begin m_code = 0; m_kind = 0; end
             else begin m_code = m_tc; m_kind = 1; end
           end else if (tick) begin
             if (m_tc == MAX_CNT - 1) begin
               m_phase = 3; m_done = 1; m_code = (1 << CNT_W) - 1; m_kind = 2;
             end else m_tc++;
           end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(ramp_en == (m_phase == 2), "R3/R7 ramp_en vs model", ramp_en, m_phase == 2);
    chk(done == m_done, "R4 done vs model", done, m_done);
    chk(code == CNT_W'(m_code), "R4/R5/R6 code vs model", code, m_code);
    chk(kind == 2'(m_kind), "R4/R5/R6 kind vs model", kind, m_kind);
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sys_rst = 1; tick = 0; cmp = 0;
    repeat (3) @(negedge clk);
    chk(ramp_en == 0 && done == 0 && code == 0 && kind == 0, "R1 reset outputs",
        {ramp_en, done, kind}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ramp_en == 0 && done == 0 && code == 0 && kind == 0, "R1 after reset",
        {ramp_en, done, kind}, 0);
  endtask

  // release system reset and check discharge length
  task automatic release_check();
    sys_rst = 0;
    for (int i = 1; i <= DISCH_CYC; i++) begin
      @(negedge clk);
      chk(ramp_en == 0, "R3 discharge low", ramp_en, 0);
    end
    @(negedge clk);
    chk(ramp_en == 1, "R3 ramp starts", ramp_en, 1);
  endtask

  // with tick held high, trip after exactly k counted ticks
  task automatic trip_after(input int k);
    tick = 1; cmp = 0;
    repeat (k) @(negedge clk);
    chk(done == 0, "R10 not done before trip", done, 0);
    chk(code == 0 && kind == 0, "R10 code idle before trip", code, 0);
    cmp = 1;
    @(negedge clk);
    cmp = 0; tick = 0;
  endtask

  initial begin
    do_reset();
    repeat (10) @(negedge clk);
    chk(ramp_en == 0 && done == 0, "R2 held in system reset", ramp_en, 0);

    release_check();
    trip_after(25);
    chk(done == 1 && kind == 2'b01 && code == 25, "R4/R9 normal code 25", code, 25);
    chk(ramp_en == 0, "R4 ramp off after trip", ramp_en, 0);

    do_reset(); release_check(); trip_after(MIN_CNT);
    chk(kind == 2'b01 && code == MIN_CNT, "R5 boundary MIN_CNT normal", code, MIN_CNT);

    do_reset(); release_check(); trip_after(MIN_CNT - 1);
    chk(done == 1 && kind == 2'b00 && code == 0, "R5 below MIN_CNT zero", kind, 0);

    do_reset(); release_check(); trip_after(0);
    chk(done == 1 && kind == 2'b00 && code == 0, "R5 instant trip zero", kind, 0);

    do_reset(); release_check(); trip_after(MAX_CNT - 1);
    chk(kind == 2'b01 && code == MAX_CNT - 1, "R6 trip at MAX_CNT-1 normal", code, MAX_CNT - 1);

    do_reset(); release_check();
    tick = 1;
    repeat (MAX_CNT - 1) @(negedge clk);
    chk(done == 0, "R6 not infinite one tick early", done, 0);
    @(negedge clk);
    chk(done == 1 && kind == 2'b10 && code == 8'hFF, "R6 infinite code", code, 255);
    tick = 0;

    // abort during measurement
    do_reset(); release_check();
    tick = 1;
    repeat (5) @(negedge clk);
    sys_rst = 1; tick = 0;
    @(negedge clk);
    chk(ramp_en == 0 && done == 0, "R7 abort in measurement", ramp_en, 0);
    repeat (4) @(negedge clk);
    release_check(); trip_after(6);
    chk(code == 6 && kind == 2'b01, "R7 restart counts from zero", code, 6);

    // abort during discharge
    do_reset();
    sys_rst = 0;
    repeat (2) @(negedge clk);
    sys_rst = 1;
    repeat (3) @(negedge clk);
    chk(ramp_en == 0, "R7 abort in discharge", ramp_en, 0);
    release_check(); trip_after(9);
    chk(code == 9, "R7 restart after discharge abort", code, 9);

    // hold after done
    for (int i = 0; i < 40; i++) begin
      sys_rst = i[0]; cmp = i[1]; tick = i[2];
      @(negedge clk);
      chk(done == 1 && code == 9 && kind == 2'b01 && ramp_en == 0, "R8 result held",
          code, 9);
    end
    sys_rst = 0; cmp = 0; tick = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: all requirements, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule